// File: doc/BRIEF.md
# Single-Bus Microcoded 8-bit Datapath

This block is the datapath of a small microcoded processor. It has one shared data bus and one shared address bus. Two working registers (R0, R1), an address register and a program counter sit on these buses. An eight-function arithmetic unit reads R0 and R1, and a 256-byte memory with a combined read/write data path hangs off both buses. Every transfer happens because one of the fifteen micro-operation lines is high in that cycle. The sequencer that produces these lines lives outside the block. The data bus is brought out so that an external instruction decoder can see fetched opcodes.

The buses are modelled as merged multiplexers rather than real tri-state wires. An undriven bus reads as zero. When two sources drive one bus in the same cycle, the bus carries the OR of the sources and a contention flag rises.

Writes to the memory are treated as level-sensitive on the part's pins. A store must therefore follow a cycle-by-cycle order:
1. Address and data settle on the buses.
2. The write level rises.
3. The enable rises.
4. The enable falls.
5. The write level falls.

The block checks this order with assertions. The array itself only captures a byte on a clock edge where enable and write are both high.

Top module: `mdp_datapath`

## Requirements
- R1: Port `mop` bit k-1 carries micro-operation k (k = 1..15). While `rst_n` is low, R0, R1, the address register and the PC read 0, and with all micro-operations low both buses read 0x00.
- R2: Micro-operation 11 loads R0 from the data bus, and micro-operation 9 loads the address register from the data bus. Without its micro-operation, each register holds its value.
- R3: Micro-operation 12 loads R1 with the ALU result. The function code is {mop13, mop14, mop15} (mop13 is the MSB): 0 pass R0, 1 shift R0 left, 2 shift R0 right, 3 R0+R1, 4 R0-R1, 5 R0 AND R1, 6 R0 OR R1, 7 NOT R0.
- R4: Data bus sources: micro-operation 8 drives R1, and a memory read (mop3 high, mop4 low) drives the byte at the address bus.
- R5: Address bus sources: micro-operation 5 drives the PC, and micro-operation 10 drives the address register.
- R6: The PC clears on reset. Otherwise micro-operation 6 loads it from the address bus, ahead of micro-operation 7, which increments it modulo 256. Otherwise it holds.
- R7: The memory stores the data bus byte at the address bus location only on a clock edge where mop3 and mop4 are both high. A cycle with write level but no enable leaves the byte unchanged.
- R8: A store keeps address and data stable from the cycle before the write level rises until it falls. The write level is high in the cycle before enable rises and stays high in the cycle after enable falls. A store that follows this order reads back the written byte.
- R9: `bus_conflict` is high in any cycle where two sources drive the same bus, and that bus then carries the OR of the sources.
- R10: Micro-operations 1 and 2 (sequencer controls) change no register and drive no bus.
- R11: Both shifts fill the vacated bit with zero, and addition and subtraction wrap modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mop | input | 15 | Micro-operation lines, bit k-1 is micro-operation k |
| dbus | output | 8 | Data bus value (to instruction decoder) |
| abus | output | 8 | Address bus value |
| r0_q | output | 8 | R0 debug view |
| r1_q | output | 8 | R1 debug view |
| ar_q | output | 8 | Address register debug view |
| pc_q | output | 8 | Program counter debug view |
| bus_conflict | output | 1 | Two or more sources on one bus this cycle |

## Verification
Some rules are checked by assertions on every cycle:
- the PC priority chain and the register load/hold rules;
- the R1 to data bus and PC to address bus paths;
- contention flagging;
- zero fill on right shifts;
- the store ordering: stable buses before the write level, write level around the enable;
- the byte captured by each qualified write.

Other behaviour is shown only by the bench's scenarios. These include:
- the full ALU function table, using operands that the bench builds up through the datapath itself;
- a round trip through memory via a proper store;
- the survival of a byte across a write-level-only cycle;
- the OR value on a contended bus;
- the silence of micro-operations 1 and 2.

// File: rtl/mdp_pkg.sv
package mdp_pkg;

  localparam int MOP_W = 15;

  // zero-based bit positions: micro-operation k sits at bit k-1
  localparam int MB_SEQ_CLR  = 0;
  localparam int MB_SEQ_LD   = 1;
  localparam int MB_MEM_EN   = 2;
  localparam int MB_MEM_WR   = 3;
  localparam int MB_PC_ABUS  = 4;
  localparam int MB_PC_LD    = 5;
  localparam int MB_PC_INC   = 6;
  localparam int MB_R1_DBUS  = 7;
  localparam int MB_AR_LD    = 8;
  localparam int MB_AR_ABUS  = 9;
  localparam int MB_R0_LD    = 10;
  localparam int MB_R1_LD    = 11;
  localparam int MB_FN_HI    = 12;
  localparam int MB_FN_MID   = 13;
  localparam int MB_FN_LO    = 14;

  typedef enum logic [2:0] {
    FN_PASS = 3'd0,
    FN_SHL  = 3'd1,
    FN_SHR  = 3'd2,
    FN_ADD  = 3'd3,
    FN_SUB  = 3'd4,
    FN_AND  = 3'd5,
    FN_OR   = 3'd6,
    FN_INV  = 3'd7
  } alu_fn_e;

  typedef struct packed {
    logic    mem_en;
    logic    mem_wr;
    logic    pc_abus;
    logic    pc_ld;
    logic    pc_inc;
    logic    r1_dbus;
    logic    ar_ld;
    logic    ar_abus;
    logic    r0_ld;
    logic    r1_ld;
    logic    seq_clr;
    logic    seq_ld;
    alu_fn_e fn;
  } ctl_t;

  function automatic ctl_t decode_mops(input logic [MOP_W-1:0] m);
    ctl_t c;
    c.mem_en  = m[MB_MEM_EN];
    c.mem_wr  = m[MB_MEM_WR];
    c.pc_abus = m[MB_PC_ABUS];
    c.pc_ld   = m[MB_PC_LD];
    c.pc_inc  = m[MB_PC_INC];
    c.r1_dbus = m[MB_R1_DBUS];
    c.ar_ld   = m[MB_AR_LD];
    c.ar_abus = m[MB_AR_ABUS];
    c.r0_ld   = m[MB_R0_LD];
    c.r1_ld   = m[MB_R1_LD];
    c.seq_clr = m[MB_SEQ_CLR];
    c.seq_ld  = m[MB_SEQ_LD];
    c.fn      = alu_fn_e'({m[MB_FN_HI], m[MB_FN_MID], m[MB_FN_LO]});
    return c;
  endfunction

endpackage

// File: rtl/mdp_alu.sv
module mdp_alu
  import mdp_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_fn_e       fn,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);

  function automatic logic [DW-1:0] alu_calc(input alu_fn_e f,
                                             input logic [DW-1:0] x,
                                             input logic [DW-1:0] z);
    logic [DW-1:0] r;
    case (f)
      FN_PASS: r = x;
      FN_SHL:  r = {x[DW-2:0], 1'b0};
      FN_SHR:  r = {1'b0, x[DW-1:1]};
      FN_ADD:  r = x + z;
      FN_SUB:  r = x - z;
      FN_AND:  r = x & z;
      FN_OR:   r = x | z;
      default: r = ~x;
    endcase
    return r;
  endfunction

  always_comb y = alu_calc(fn, a, b);

  // R11
  always_comb begin
    shr_fill_chk: assert (fn != FN_SHR || y[DW-1] == 1'b0);
  end

  // R11
  always_comb begin
    shl_fill_chk: assert (fn != FN_SHL || y[0] == 1'b0);
  end

endmodule

// File: rtl/mdp_bus.sv
module mdp_bus #(
  parameter int W = 8,
  parameter int N = 2
) (
  input  logic [N-1:0]   drv_en,
  input  logic [N*W-1:0] drv_src,
  output logic [W-1:0]   bus,
  output logic           conflict
);

  logic [W-1:0] gated [N];

  for (genvar i = 0; i < N; i++) begin : g_src
    assign gated[i] = drv_en[i] ? drv_src[i*W +: W] : '0;
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < N; i++) bus = bus | gated[i];
  end

  assign conflict = ($countones(drv_en) > 1);

endmodule

// File: rtl/mdp_pc.sv
module mdp_pc #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          inc,
  input  logic [AW-1:0] abus,
  output logic [AW-1:0] pc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pc <= '0;
    else if (ld)  pc <= abus;
    else if (inc) pc <= pc + AW'(1);
  end

  // R6
  pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> pc == $past(abus));

  // R6
  pc_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && inc) |=> pc == AW'($past(pc) + AW'(1)));

  // R6
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !inc) |=> $stable(pc));

endmodule

// File: rtl/mdp_regs.sv
module mdp_regs #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          r0_ld,
  input  logic          r1_ld,
  input  logic          ar_ld,
  input  logic [DW-1:0] dbus,
  input  logic [DW-1:0] alu_y,
  output logic [DW-1:0] r0,
  output logic [DW-1:0] r1,
  output logic [AW-1:0] ar
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     r0 <= '0;
    else if (r0_ld) r0 <= dbus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     r1 <= '0;
    else if (r1_ld) r1 <= alu_y;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ar <= '0;
    else if (ar_ld) ar <= AW'(dbus);
  end

  // R2
  r0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r0_ld |=> r0 == $past(dbus));

  // R2
  r0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !r0_ld |=> $stable(r0));

  // R2
  ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ar_ld |=> $stable(ar));

  // R3
  r1_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r1_ld |=> r1 == $past(alu_y));

endmodule

// File: rtl/mdp_mem.sv
module mdp_mem #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rd_drive
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];
  logic          wr_fire;
  logic          armed;

  assign wr_fire  = en && wr;
  assign rd_drive = en && !wr;
  assign rdata    = cells[addr];

  always_ff @(posedge clk) begin
    if (wr_fire) cells[addr] <= wdata;
  end

  // marks that one post-reset edge has passed, so $past is meaningful
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R7
  mem_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> cells[$past(addr)] == $past(wdata));

  // R8
  wr_before_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(en) && wr) |-> $past(wr));

  // R8
  wr_after_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $fell(en) && $past(wr)) |-> wr);

  // R8
  wr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(wr)) |-> ($stable(addr) && $stable(wdata)));

  // R8
  wr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr && $past(wr)) |-> ($stable(addr) && $stable(wdata)));

endmodule

// File: rtl/mdp_datapath.sv
module mdp_datapath
  import mdp_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MOP_W-1:0] mop,
  output logic [DW-1:0]    dbus,
  output logic [AW-1:0]    abus,
  output logic [DW-1:0]    r0_q,
  output logic [DW-1:0]    r1_q,
  output logic [AW-1:0]    ar_q,
  output logic [AW-1:0]    pc_q,
  output logic             bus_conflict
);

  localparam int N_DSRC = 2;
  localparam int N_ASRC = 2;

  ctl_t          ctl;
  logic [DW-1:0] alu_y;
  logic [DW-1:0] mem_q;
  logic          mem_rd;
  logic          d_conflict;
  logic          a_conflict;

  assign ctl = decode_mops(mop);

  mdp_alu #(.DW(DW)) u_alu (
    .fn (ctl.fn),
    .a  (r0_q),
    .b  (r1_q),
    .y  (alu_y)
  );

  mdp_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .r0_ld (ctl.r0_ld),
    .r1_ld (ctl.r1_ld),
    .ar_ld (ctl.ar_ld),
    .dbus  (dbus),
    .alu_y (alu_y),
    .r0    (r0_q),
    .r1    (r1_q),
    .ar    (ar_q)
  );

  mdp_pc #(.AW(AW)) u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (ctl.pc_ld),
    .inc   (ctl.pc_inc),
    .abus  (abus),
    .pc    (pc_q)
  );

  mdp_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctl.mem_en),
    .wr       (ctl.mem_wr),
    .addr     (abus),
    .wdata    (dbus),
    .rdata    (mem_q),
    .rd_drive (mem_rd)
  );

  mdp_bus #(.W(DW), .N(N_DSRC)) u_dbus (
    .drv_en   ({mem_rd, ctl.r1_dbus}),
    .drv_src  ({mem_q, r1_q}),
    .bus      (dbus),
    .conflict (d_conflict)
  );

  mdp_bus #(.W(AW), .N(N_ASRC)) u_abus (
    .drv_en   ({ctl.ar_abus, ctl.pc_abus}),
    .drv_src  ({ar_q, pc_q}),
    .bus      (abus),
    .conflict (a_conflict)
  );

  assign bus_conflict = d_conflict | a_conflict;

  // R4
  dbus_r1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mop[MB_R1_DBUS] && !mem_rd) |-> dbus == r1_q);

  // R5
  abus_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mop[MB_PC_ABUS] && !mop[MB_AR_ABUS]) |-> abus == pc_q);

  // R9
  addr_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mop[MB_PC_ABUS] && mop[MB_AR_ABUS]) |-> bus_conflict);

  // R9
  no_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_conflict |-> (!(mop[MB_PC_ABUS] && mop[MB_AR_ABUS]) &&
                       !(mop[MB_R1_DBUS] && mem_rd)));

endmodule

// File: tb/mdp_datapath_tb.sv
`timescale 1ns/1ps
module mdp_datapath_tb;

  localparam int CLK_HALF = 5;

  localparam logic [14:0] M1  = 15'h0001;
  localparam logic [14:0] M2  = 15'h0002;
  localparam logic [14:0] M3  = 15'h0004;
  localparam logic [14:0] M4  = 15'h0008;
  localparam logic [14:0] M5  = 15'h0010;
  localparam logic [14:0] M6  = 15'h0020;
  localparam logic [14:0] M7  = 15'h0040;
  localparam logic [14:0] M8  = 15'h0080;
  localparam logic [14:0] M9  = 15'h0100;
  localparam logic [14:0] M10 = 15'h0200;
  localparam logic [14:0] M11 = 15'h0400;
  localparam logic [14:0] M12 = 15'h0800;

  // {fn[2:0], a[7:0], b[7:0], expected[7:0]}
  localparam logic [26:0] ALU_VEC [8] = '{
    {3'd0, 8'h5A, 8'h33, 8'h5A},
    {3'd1, 8'hC3, 8'h11, 8'h86},
    {3'd2, 8'hC3, 8'h11, 8'h61},
    {3'd3, 8'hF0, 8'h25, 8'h15},
    {3'd4, 8'h10, 8'h20, 8'hF0},
    {3'd5, 8'hCC, 8'hAA, 8'h88},
    {3'd6, 8'hCC, 8'hAA, 8'hEE},
    {3'd7, 8'h3C, 8'h00, 8'hC3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] mop = '0;
  logic [7:0]  dbus, abus, r0_q, r1_q, ar_q, pc_q;
  logic        bus_conflict;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  mdp_datapath u_dut (
    .clk (clk), .rst_n (rst_n), .mop (mop),
    .dbus (dbus), .abus (abus), .r0_q (r0_q), .r1_q (r1_q),
    .ar_q (ar_q), .pc_q (pc_q), .bus_conflict (bus_conflict)
  );

  always #CLK_HALF clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [14:0] fn_bits(input logic [2:0] f);
    return (15'(f[2]) << 12) | (15'(f[1]) << 13) | (15'(f[0]) << 14);
  endfunction

  // apply lines across one rising edge; returns at the next falling edge
  task automatic tick(input logic [14:0] m);
    mop = m;
    @(negedge clk);
    mop = '0;
  endtask

  // apply lines without a clock edge and let combinational paths settle
  task automatic peek(input logic [14:0] m);
    mop = m;
    #1;
  endtask

  task automatic alu(input logic [2:0] f);
    tick(M12 | fn_bits(f));
  endtask

  task automatic mv_r1_r0();
    tick(M8 | M11);
  endtask

  // leaves R1 = v using only ALU steps and R1->R0 moves
  task automatic build(input logic [7:0] v);
    alu(3'd0);
    alu(3'd4);
    for (int i = 7; i >= 0; i--) begin
      mv_r1_r0();
      if (v[i]) begin
        alu(3'd7); mv_r1_r0(); alu(3'd1); mv_r1_r0(); alu(3'd7);
      end else begin
        alu(3'd1);
      end
    end
  endtask

  task automatic set_ar(input logic [7:0] a);
    build(a);
    tick(M8 | M9);
  endtask

  task automatic store(input logic [7:0] a, input logic [7:0] v);
    set_ar(a);
    build(v);
    tick(M8 | M10);
    tick(M8 | M10 | M4);
    tick(M8 | M10 | M4 | M3);
    tick(M8 | M10 | M4);
    tick(M8 | M10);
  endtask

  initial begin
    logic [7:0] s_r0, s_r1, s_ar, s_pc;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "r0 reset", r0_q, 8'h00);
    chk("R1", "r1 reset", r1_q, 8'h00);
    chk("R1", "ar reset", ar_q, 8'h00);
    chk("R1", "pc reset", pc_q, 8'h00);
    chk("R1", "dbus idle", dbus, 8'h00);
    chk("R1", "abus idle", abus, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 increment and R5 PC onto address bus
    tick(M7); tick(M7); tick(M7);
    chk("R6", "pc after 3 inc", pc_q, 8'h03);
    peek(M5);
    chk("R5", "abus from pc", abus, 8'h03);
    chk("R9", "single driver no conflict", {7'd0, bus_conflict}, 8'h00);

    // R3 building a value, R2 loads, R4/R5 drivers
    build(8'h5A);
    chk("R3", "built r1", r1_q, 8'h5A);
    mv_r1_r0();
    chk("R2", "r0 load from dbus", r0_q, 8'h5A);
    tick(M8 | M9);
    chk("R2", "ar load from dbus", ar_q, 8'h5A);
    peek(M10);
    chk("R5", "abus from ar", abus, 8'h5A);
    peek(M8);
    chk("R4", "dbus from r1", dbus, 8'h5A);

    // R6 load wins over increment, then wrap
    tick(M10 | M6 | M7);
    chk("R6", "load beats inc", pc_q, 8'h5A);
    tick(M7);
    chk("R6", "inc after load", pc_q, 8'h5B);
    set_ar(8'hFF);
    tick(M10 | M6);
    chk("R6", "load ff", pc_q, 8'hFF);
    tick(M7);
    chk("R6", "inc wraps", pc_q, 8'h00);

    // R3 / R11 function table through memory-loaded operands
    for (int k = 0; k < 8; k++) begin
      logic [2:0] f;
      logic [7:0] a, b, e;
      {f, a, b, e} = ALU_VEC[k];
      store(8'h40, a);
      set_ar(8'h40);
      build(b);
      tick(M10 | M3 | M11);
      chk("R4", "memory read into r0", r0_q, a);
      alu(f);
      chk((f == 3'd1 || f == 3'd2 || f == 3'd3 || f == 3'd4) ? "R11" : "R3",
          $sformatf("alu fn %0d", f), r1_q, e);
    end

    // R7 / R8 ordered store and readback
    store(8'h81, 8'hA5);
    store(8'h82, 8'h3C);
    set_ar(8'h81);
    peek(M10 | M3);
    chk("R8", "stored byte 81", dbus, 8'hA5);
    set_ar(8'h82);
    peek(M10 | M3);
    chk("R7", "stored byte 82", dbus, 8'h3C);

    // R7 write level without enable leaves byte intact
    set_ar(8'h81);
    build(8'h11);
    tick(M8 | M10);
    tick(M8 | M10 | M4);
    tick(M8 | M10);
    peek(M10 | M3);
    chk("R7", "no write without enable", dbus, 8'hA5);

    // R9 contention on both buses; R1 = 0x11, AR = 0x81, mem[81] = A5
    peek(M5 | M10);
    chk("R9", "abus conflict flag", {7'd0, bus_conflict}, 8'h01);
    chk("R9", "abus OR value", abus, pc_q | 8'h81);
    peek(M8 | M10 | M3);
    chk("R9", "dbus conflict flag", {7'd0, bus_conflict}, 8'h01);
    chk("R9", "dbus OR value", dbus, 8'hB5);

    // R10 sequencer lines are inert
    @(negedge clk);
    mop = '0;
    s_r0 = r0_q; s_r1 = r1_q; s_ar = ar_q; s_pc = pc_q;
    peek(M1 | M2);
    chk("R10", "dbus quiet", dbus, 8'h00);
    chk("R10", "abus quiet", abus, 8'h00);
    tick(M1 | M2);
    chk("R10", "r0 kept", r0_q, s_r0);
    chk("R10", "r1 kept", r1_q, s_r1);
    chk("R10", "ar kept", ar_q, s_ar);
    chk("R10", "pc kept", pc_q, s_pc);

    // R1 asynchronous reset mid-run
    tick(M7);
    rst_n = 1'b0;
    #1;
    chk("R1", "pc async clear", pc_q, 8'h00);
    chk("R1", "r1 async clear", r1_q, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_HALF * 2 * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule